// File: doc/BRIEF.md
# Timer with Master Trigger Outputs

This block is an up-counting timer built to pace other timers and converters. A prescaler divides the clock. The counter then counts prescaled ticks from zero up to a programmable top value and wraps to zero. Each wrap produces a one-clock update pulse, so update pulses repeat every (divider+1)·(top+1) clock cycles. The top value can be buffered, in which case a new value waits for the next update event. Unbuffered, a new value takes effect at once. A software force-update strobe restarts the period and loads the buffered values without waiting.

Two trigger outputs are offered to neighbouring timers. A 3-bit selector for the first output and a 4-bit selector for the second each choose the source: the force strobe, the run state, the update pulse, or the levels and edges of up to six compare reference signals that arrive as plain inputs. The second output can be left out by parameter. When it is left out, its selector cannot be written and reads as zero.

All settings go through a small write/read register bus with a combinational read port.

Top module: `trig_timer`

## Requirements
- R1: While running, update pulses repeat every (D+1)·(T+1) clock cycles, where D is the divider at address 1 and T is the top value at address 2.
- R2: The count steps by one per prescaled tick. On a tick where the count is at or above the effective top, the count returns to 0, and `upd_o` is high for the following clock.
- R3: CTRL bit 1 (buffer) selects how a TOP write at address 2 takes effect. When the bit is set, the write applies at the next update event. When it is clear, the write applies from the next tick.
- R4: A DIV write at address 1 takes effect only at the next update event, and the prescaler counter restarts at 0 on every update event.
- R5: Writing CTRL (address 0) with bit 2 set does four things: it loads the divider and top shadows, clears the count and the prescaler, and raises `upd_o` on the next clock. Bit 2 always reads as 0.
- R6: CTRL bit 0 (run) starts counting. While it is clear, the count holds its value.
- R7: COUNT at address 3 reads the live count, and a write to it replaces the count.
- R8: The first selector is TRIGSEL bits [2:0] at address 4. Its codes are: 0 pulse on force-update, 1 follow run, 2 update pulse, 3 rising edge of `ref_in[0]`, 4–7 level of `ref_in[0..3]`. The output is registered, so it lags its source by one clock.
- R9: The second selector is TRIGSEL bits [7:4]. Codes 0–7 act as in R8. The remaining codes are: 8 and 9 level of `ref_in[4]` and `ref_in[5]`; 10 rise of `ref_in[3]`; 11 rise of `ref_in[5]`; 12 rise of `ref_in[3]` or rise of `ref_in[5]`; 13 rise of `ref_in[3]` or fall of `ref_in[5]`; 14 rise of `ref_in[4]` or rise of `ref_in[5]`; 15 rise of `ref_in[4]` or fall of `ref_in[5]`.
- R10: With HAS_TRIG2 = 0, writes to TRIGSEL bits [7:4] are ignored, those bits read as 0, and `trg_b_o` stays low.
- R11: After reset, every register reads 0 and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 3 | Register address for reads and writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| ref_in | input | 6 | Compare reference signals of channels 1–6 |
| upd_o | output | 1 | One-clock update pulse |
| trg_a_o | output | 1 | First trigger output |
| trg_b_o | output | 1 | Second trigger output |

## Verification
The bench builds two copies of the block. One uses the default 16-bit widths with the second output present. The other sets HAS_TRIG2 to 0, so the ignored selector write and the silent second output can be observed. Small divider and top values such as 0/0, 1/0 and 2/3 keep each period to a few cycles. This makes single-cycle wrap, back-to-back update pulses, and the boundary between buffered and immediate reloads reachable in short runs.

// File: rtl/trig_timer_pkg.sv
package trig_timer_pkg;

  localparam int ADDR_W = 3;
  localparam int NREF   = 6;

  localparam logic [ADDR_W-1:0] A_CTRL    = 3'd0;
  localparam logic [ADDR_W-1:0] A_DIV     = 3'd1;
  localparam logic [ADDR_W-1:0] A_TOP     = 3'd2;
  localparam logic [ADDR_W-1:0] A_COUNT   = 3'd3;
  localparam logic [ADDR_W-1:0] A_TRIGSEL = 3'd4;

  localparam int B_RUN   = 0;
  localparam int B_BUF   = 1;
  localparam int B_FORCE = 2;

  typedef enum logic [3:0] {
    TS_FORCE   = 4'd0,
    TS_RUN     = 4'd1,
    TS_UPDATE  = 4'd2,
    TS_EDGE1   = 4'd3,
    TS_LVL1    = 4'd4,
    TS_LVL2    = 4'd5,
    TS_LVL3    = 4'd6,
    TS_LVL4    = 4'd7,
    TS_LVL5    = 4'd8,
    TS_LVL6    = 4'd9,
    TS_EDGE4   = 4'd10,
    TS_EDGE6   = 4'd11,
    TS_R4_R6   = 4'd12,
    TS_R4_F6   = 4'd13,
    TS_R5_R6   = 4'd14,
    TS_R5_F6   = 4'd15
  } trig_src_e;

  typedef struct packed {
    logic run;
    logic force_upd;
    logic upd;
  } tmr_ev_t;

  function automatic logic trig_pick(input logic [3:0] mode, input tmr_ev_t ev,
                                     input logic [NREF-1:0] lvl,
                                     input logic [NREF-1:0] rise,
                                     input logic [NREF-1:0] fall);
    logic r;
    case (trig_src_e'(mode))
      TS_FORCE:  r = ev.force_upd;
      TS_RUN:    r = ev.run;
      TS_UPDATE: r = ev.upd;
      TS_EDGE1:  r = rise[0];
      TS_LVL1:   r = lvl[0];
      TS_LVL2:   r = lvl[1];
      TS_LVL3:   r = lvl[2];
      TS_LVL4:   r = lvl[3];
      TS_LVL5:   r = lvl[4];
      TS_LVL6:   r = lvl[5];
      TS_EDGE4:  r = rise[3];
      TS_EDGE6:  r = rise[5];
      TS_R4_R6:  r = rise[3] | rise[5];
      TS_R4_F6:  r = rise[3] | fall[5];
      TS_R5_R6:  r = rise[4] | rise[5];
      TS_R5_F6:  r = rise[4] | fall[5];
      default:   r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/tt_regs.sv
module tt_regs import trig_timer_pkg::*; #(
  parameter int DATA_W    = 16,
  parameter int CNT_W     = 16,
  parameter int PSC_W     = 16,
  parameter bit HAS_TRIG2 = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  cnt_live,
  output logic              run,
  output logic              buffered,
  output logic              force_upd,
  output logic              cnt_load,
  output logic [PSC_W-1:0]  psc_pre,
  output logic [CNT_W-1:0]  top_pre,
  output logic [2:0]        mode_a,
  output logic [3:0]        mode_b
);

  logic wr_ctrl, wr_trig;

  assign wr_ctrl   = bus_wr && (bus_addr == A_CTRL);
  assign wr_trig   = bus_wr && (bus_addr == A_TRIGSEL);
  assign force_upd = wr_ctrl && bus_wdata[B_FORCE];
  assign cnt_load  = bus_wr && (bus_addr == A_COUNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      buffered <= 1'b0;
      psc_pre  <= '0;
      top_pre  <= '0;
      mode_a   <= '0;
    end else begin
      if (wr_ctrl) begin
        run      <= bus_wdata[B_RUN];
        buffered <= bus_wdata[B_BUF];
      end
      if (bus_wr && bus_addr == A_DIV) psc_pre <= bus_wdata[PSC_W-1:0];
      if (bus_wr && bus_addr == A_TOP) top_pre <= bus_wdata[CNT_W-1:0];
      if (wr_trig) mode_a <= bus_wdata[2:0];
    end
  end

  generate
    if (HAS_TRIG2) begin : g_sel_b
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mode_b <= '0;
        else if (wr_trig) mode_b <= bus_wdata[7:4];
      end
    end else begin : g_no_sel_b
      assign mode_b = '0;
    end
  endgenerate

  always_comb begin
    case (bus_addr)
      A_CTRL:    bus_rdata = DATA_W'({buffered, run});
      A_DIV:     bus_rdata = DATA_W'(psc_pre);
      A_TOP:     bus_rdata = DATA_W'(top_pre);
      A_COUNT:   bus_rdata = DATA_W'(cnt_live);
      A_TRIGSEL: bus_rdata = DATA_W'({mode_b, 1'b0, mode_a});
      default:   bus_rdata = '0;
    endcase
  end

  assert_ctrl_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(run));

endmodule

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             upd_evt,
  input  logic [PSC_W-1:0] psc_pre,
  output logic             tick
);

  logic [PSC_W-1:0] psc_shadow, psc_cnt;

  function automatic logic [PSC_W-1:0] psc_step(input logic [PSC_W-1:0] c);
    return c + 1'b1;
  endfunction

  assign tick = run && (psc_cnt == psc_shadow);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_cnt    <= '0;
      psc_shadow <= '0;
    end else if (upd_evt) begin
      psc_cnt    <= '0;
      psc_shadow <= psc_pre;
    end else if (tick) begin
      psc_cnt    <= '0;
    end else if (run) begin
      psc_cnt    <= psc_step(psc_cnt);
    end
  end

  assert_psc_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    psc_cnt <= psc_shadow);

  assert_psc_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_evt |=> (psc_cnt == '0));

  assert_psc_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick && !upd_evt) |=> (psc_cnt == PSC_W'($past(psc_cnt) + 1'b1)));

endmodule

// File: rtl/tt_counter.sv
module tt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             force_upd,
  input  logic             buffered,
  input  logic             cnt_load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] top_pre,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap,
  output logic             upd_evt,
  output logic             upd_q
);

  logic [CNT_W-1:0] top_shadow, top_eff;

  function automatic logic at_top(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] t);
    return c >= t;
  endfunction

  function automatic logic [CNT_W-1:0] count_step(input logic [CNT_W-1:0] c);
    return c + 1'b1;
  endfunction

  assign top_eff = buffered ? top_shadow : top_pre;
  assign wrap    = tick && at_top(cnt, top_eff);
  assign upd_evt = wrap || force_upd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      top_shadow <= '0;
      upd_q      <= 1'b0;
    end else begin
      upd_q <= upd_evt;
      if (!buffered || upd_evt) top_shadow <= top_pre;
      if (force_upd)     cnt <= '0;
      else if (cnt_load) cnt <= load_val;
      else if (wrap)     cnt <= '0;
      else if (tick)     cnt <= count_step(cnt);
    end
  end

  assert_wrap_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !force_upd && !cnt_load) |=> (cnt == '0 && upd_q));

  assert_shadow_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (buffered && !upd_evt) |=> $stable(top_shadow));

  assert_force_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    force_upd |=> (upd_q && cnt == '0));

  assert_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !force_upd && !cnt_load) |=> $stable(cnt));

endmodule

// File: rtl/tt_trigsel.sv
module tt_trigsel import trig_timer_pkg::*; #(
  parameter bit HAS_TRIG2 = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  tmr_ev_t         ev,
  input  logic [NREF-1:0] ref_in,
  input  logic [2:0]      mode_a,
  input  logic [3:0]      mode_b,
  output logic            trg_a,
  output logic            trg_b
);

  logic [NREF-1:0] ref_q, rise, fall;

  assign rise = ref_in & ~ref_q;
  assign fall = ~ref_in & ref_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= '0;
      trg_a <= 1'b0;
    end else begin
      ref_q <= ref_in;
      trg_a <= trig_pick({1'b0, mode_a}, ev, ref_in, rise, fall);
    end
  end

  generate
    if (HAS_TRIG2) begin : g_out_b
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trg_b <= 1'b0;
        else        trg_b <= trig_pick(mode_b, ev, ref_in, rise, fall);
      end

      assert_b_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_b == 4'd8) |=> (trg_b == $past(ref_in[4])));
    end else begin : g_out_b_off
      assign trg_b = 1'b0;
    end
  endgenerate

  assert_a_follow_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_a == 3'd1) |=> (trg_a == $past(ev.run)));

  assert_a_update_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_a == 3'd2) |=> (trg_a == $past(ev.upd)));

endmodule

// File: rtl/trig_timer.sv
module trig_timer import trig_timer_pkg::*; #(
  parameter int DATA_W    = 16,
  parameter int CNT_W     = 16,
  parameter int PSC_W     = 16,
  parameter bit HAS_TRIG2 = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NREF-1:0]   ref_in,
  output logic              upd_o,
  output logic              trg_a_o,
  output logic              trg_b_o
);

  logic             run, buffered, force_upd, cnt_load;
  logic [PSC_W-1:0] psc_pre;
  logic [CNT_W-1:0] top_pre, cnt;
  logic [2:0]       mode_a;
  logic [3:0]       mode_b;
  logic             tick, wrap, upd_evt;
  tmr_ev_t          ev;

  tt_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .PSC_W(PSC_W), .HAS_TRIG2(HAS_TRIG2)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_live(cnt),
    .run(run), .buffered(buffered), .force_upd(force_upd), .cnt_load(cnt_load),
    .psc_pre(psc_pre), .top_pre(top_pre), .mode_a(mode_a), .mode_b(mode_b)
  );

  tt_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .run(run), .upd_evt(upd_evt),
    .psc_pre(psc_pre), .tick(tick)
  );

  tt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .force_upd(force_upd),
    .buffered(buffered), .cnt_load(cnt_load), .load_val(bus_wdata[CNT_W-1:0]),
    .top_pre(top_pre), .cnt(cnt), .wrap(wrap), .upd_evt(upd_evt), .upd_q(upd_o)
  );

  assign ev.run       = run;
  assign ev.force_upd = force_upd;
  assign ev.upd       = upd_evt;

  tt_trigsel #(.HAS_TRIG2(HAS_TRIG2)) u_trig (
    .clk(clk), .rst_n(rst_n), .ev(ev), .ref_in(ref_in),
    .mode_a(mode_a), .mode_b(mode_b), .trg_a(trg_a_o), .trg_b(trg_b_o)
  );

  assert_update_only_on_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap && !force_upd) |=> !upd_o);

endmodule

// File: tb/tb_trig_timer.sv
`timescale 1ns/1ps
module tb_trig_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [5:0]  ref_in = '0;
  logic        use_lite = 1'b0;
  logic        wr_main, wr_lite;
  logic [15:0] rd_main, rd_lite;
  logic        upd_o, trg_a_o, trg_b_o;
  logic        upd_l, trg_a_l, trg_b_l;

  int total = 0, bad = 0;
  int cyc = 0, last_cyc = 0, last_gap = 0, n_upd = 0;
  logic [15:0] rd;

  always #10 clk = ~clk;

  assign wr_main = bus_wr & ~use_lite;
  assign wr_lite = bus_wr & use_lite;

  trig_timer dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr_main), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_main), .ref_in(ref_in),
    .upd_o(upd_o), .trg_a_o(trg_a_o), .trg_b_o(trg_b_o)
  );

  trig_timer #(.HAS_TRIG2(1'b0)) dut_lite (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr_lite), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rd_lite), .ref_in(ref_in),
    .upd_o(upd_l), .trg_a_o(trg_a_l), .trg_b_o(trg_b_l)
  );

  always @(negedge clk) if (rst_n) begin
    cyc = cyc + 1;
    if (upd_o) begin
      last_gap = cyc - last_cyc;
      last_cyc = cyc;
      n_upd = n_upd + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    #1;
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = use_lite ? rd_lite : rd_main;
  endtask

  task automatic wait_upd();
    int start = n_upd;
    while (n_upd == start) step(1);
  endtask

  // divider, top, buffer flag; starts running with a force update
  task automatic config_run(input int p, input int a, input bit bufd);
    bus_write(3'd1, 16'(p));
    bus_write(3'd2, 16'(a));
    bus_write(3'd0, {13'd0, 1'b1, bufd, 1'b1});
  endtask

  task automatic test_reset();
    for (int i = 0; i < 5; i++) begin
      bus_read(3'(i), rd);
      chk("R11 reg read", rd, 0);
    end
    chk("R11 upd_o", upd_o, 0);
    chk("R11 trg_a", trg_a_o, 0);
    chk("R11 trg_b", trg_b_o, 0);
  endtask

  task automatic test_period();
    config_run(0, 4, 1'b0); wait_upd(); wait_upd();
    chk("R1 period d0 t4", last_gap, 5);
    config_run(2, 3, 1'b0); wait_upd(); wait_upd();
    chk("R1 period d2 t3", last_gap, 12);
    config_run(1, 0, 1'b0); wait_upd(); wait_upd();
    chk("R2 period d1 t0", last_gap, 2);
    config_run(0, 0, 1'b0); wait_upd(); wait_upd();
    chk("R2 back-to-back wrap", last_gap, 1);
  endtask

  task automatic test_count_rw();
    bus_write(3'd1, 16'd0);
    bus_write(3'd2, 16'd20);
    bus_write(3'd0, 16'b100);
    bus_write(3'd3, 16'd7);
    bus_read(3'd3, rd);
    chk("R7 count write/read", rd, 7);
    bus_write(3'd0, 16'd1);
    bus_write(3'd0, 16'd0);
    bus_read(3'd3, rd);
    chk("R6 one tick counted", rd, 8);
    step(5);
    bus_read(3'd3, rd);
    chk("R6 frozen when stopped", rd, 8);
  endtask

  task automatic test_buffered();
    config_run(0, 9, 1'b1); wait_upd(); wait_upd();
    bus_write(3'd2, 16'd3);
    wait_upd();
    chk("R3 buffered old top kept", last_gap, 10);
    wait_upd();
    chk("R3 buffered new top applied", last_gap, 4);
    config_run(0, 9, 1'b0); wait_upd(); wait_upd();
    bus_write(3'd2, 16'd3);
    wait_upd();
    chk("R3 unbuffered immediate", last_gap, 4);
  endtask

  task automatic test_divider();
    config_run(0, 3, 1'b0); wait_upd(); wait_upd();
    bus_write(3'd1, 16'd1);
    wait_upd();
    chk("R4 divider waits for update", last_gap, 4);
    wait_upd();
    chk("R4 divider applied", last_gap, 8);
  endtask

  task automatic test_force();
    config_run(0, 9, 1'b1); wait_upd(); wait_upd();
    step(3);
    bus_write(3'd2, 16'd3);
    bus_write(3'd0, 16'b111);
    chk("R5 update pulse on force", upd_o, 1);
    chk("R8 mode0 pulse on force", trg_a_o, 1);
    bus_read(3'd3, rd);
    chk("R5 count cleared", rd, 0);
    bus_read(3'd0, rd);
    chk("R5 force bit reads 0", rd, 3);
    step(1);
    chk("R8 mode0 pulse ends", trg_a_o, 0);
    wait_upd();
    chk("R5 shadow loaded by force", last_gap, 4);
  endtask

  task automatic edge_chk(input bit sel_b, input logic [5:0] r0, input logic [5:0] r1,
                          input int exp, input string req);
    ref_in = r0; step(2);
    ref_in = r1; step(1);
    chk(req, sel_b ? trg_b_o : trg_a_o, exp);
    step(1);
    chk(req, sel_b ? trg_b_o : trg_a_o, 0);
    ref_in = '0; step(2);
  endtask

  task automatic test_trig_a();
    int mism = 0;
    bus_write(3'd4, 16'h22);
    config_run(0, 2, 1'b0);
    for (int i = 0; i < 12; i++) begin
      step(1);
      if (trg_a_o !== upd_o) mism++;
      if (trg_b_o !== upd_o) mism++;
    end
    chk("R8 R9 update mode tracks upd_o", mism, 0);
    bus_write(3'd0, 16'd0);
    bus_write(3'd4, 16'h01);
    step(2);
    bus_write(3'd0, 16'd1);
    chk("R8 enable mode lags run", trg_a_o, 0);
    step(1);
    chk("R8 enable mode follows run", trg_a_o, 1);
    bus_write(3'd0, 16'd0);
    step(1);
    chk("R8 enable mode follows stop", trg_a_o, 0);
    bus_write(3'd4, 16'h03);
    edge_chk(1'b0, 6'b000000, 6'b000001, 1, "R8 mode3 rise ref0");
    bus_write(3'd4, 16'h05);
    ref_in = 6'b000010; step(1);
    chk("R8 mode5 level ref1 high", trg_a_o, 1);
    ref_in = 6'b000000; step(1);
    chk("R8 mode5 level ref1 low", trg_a_o, 0);
  endtask

  task automatic test_trig_b();
    bus_write(3'd4, 16'h80);
    ref_in = 6'b010000; step(1);
    chk("R9 mode8 level ref4", trg_b_o, 1);
    ref_in = 6'b000000; step(1);
    chk("R9 mode8 level low", trg_b_o, 0);
    bus_write(3'd4, 16'hA0);
    edge_chk(1'b1, 6'b000000, 6'b001000, 1, "R9 mode10 rise ref3");
    bus_write(3'd4, 16'hB0);
    edge_chk(1'b1, 6'b000000, 6'b100000, 1, "R9 mode11 rise ref5");
    bus_write(3'd4, 16'hD0);
    edge_chk(1'b1, 6'b100000, 6'b000000, 1, "R9 mode13 fall ref5");
    bus_write(3'd4, 16'hF0);
    edge_chk(1'b1, 6'b000000, 6'b100000, 0, "R9 mode15 ignores rise ref5");
    edge_chk(1'b1, 6'b000000, 6'b010000, 1, "R9 mode15 rise ref4");
    bus_write(3'd4, 16'hA3);
    bus_read(3'd4, rd);
    chk("R9 selector readback", rd, 16'hA3);
  endtask

  task automatic test_lite();
    int hits = 0;
    use_lite = 1'b1;
    bus_write(3'd4, 16'hF5);
    bus_read(3'd4, rd);
    chk("R10 second field reads 0", rd, 16'h05);
    ref_in = 6'b000010; step(1);
    chk("R10 first output still works", trg_a_l, 1);
    for (int i = 0; i < 4; i++) begin
      ref_in = (i % 2 == 0) ? 6'b110000 : 6'b000000;
      step(1);
      if (trg_b_l !== 1'b0) hits++;
    end
    chk("R10 second output silent", hits, 0);
    ref_in = '0;
    use_lite = 1'b0;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    step(1);
    test_reset();
    test_period();
    test_count_rw();
    test_force();
    test_buffered();
    test_divider();
    test_trig_a();
    test_trig_b();
    test_lite();
    finish_run();
  end

endmodule